// File: doc/BRIEF.md
# Framed Serial Word Output Port

This block takes 16-bit two's-complement words from an upstream producer and sends each one out on a three-wire port that supplies its own clock. The port has a serial clock, a data line and an active-low frame line. It also drives inverted copies of the clock and data lines so that a board can route them as balanced pairs. The port works on a fixed grid of 64 master-clock cycles. Each slot of that grid carries at most one word, so at full rate one word leaves every 64 cycles.

Words enter through a valid/ready handshake into a one-entry holding buffer. A word is taken when `in_valid` and `in_ready` are both high at a rising clock edge. After that, `in_ready` stays low until the buffer is emptied at the next slot boundary. While `in_ready` is low the producer must wait, and whatever it presents on `in_data` has no effect. Once loaded, the word is serialised in the next slot. The serial clock is one third of the master clock, high for one cycle and low for two. It toggles only inside a frame.

Top module: `serial_word_port`

## Requirements
- R1: During reset `sclk` is 0, `sdo` is 0, `frame_n` is 1 and `in_ready` is 1.
- R2: A word is accepted only on a rising edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 from the edge after an acceptance until the buffer is released at the next slot boundary. While `in_ready` is 0, `in_valid` and `in_data` are ignored.
- R3: Slot boundaries are the rising edges numbered 64·m after reset release, with edge 1 being the first edge after release. A held word is loaded at the first boundary after its acceptance. `frame_n` falls in the cycle after that boundary edge, and never at any other time.
- R4: Inside a frame `sclk` repeats low, low, high. Each high lasts one master-clock cycle and each low phase lasts two. There are exactly 16 high pulses per frame.
- R5: `frame_n` stays 0 for 48 master-clock cycles. The first `sclk` rise comes 2 cycles after `frame_n` falls, and `frame_n` returns to 1 one cycle after the last `sclk` rise.
- R6: `sdo` carries the word most significant bit first, with bit 15 sent first. If frame cycle k runs from 0 to 47, then `sdo` equals bit 15−⌊k/3⌋. `sdo` never changes at an `sclk` rise. It changes only where `sclk` falls or where the frame begins or ends.
- R7: Outside a frame (`frame_n` = 1), `sclk` is 0 and `sdo` is 0.
- R8: `sclk_n` is always the inverse of `sclk`, and `sdo_n` is always the inverse of `sdo`.
- R9: Words leave in acceptance order, one per slot, with frame starts 64 cycles apart under continuous supply. A slot with no held word stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Producer has a word on `in_data` |
| in_ready | output | 1 | Holding buffer is empty and can take a word |
| in_data | input | 16 | Two's-complement word to send |
| sclk | output | 1 | Serial clock, gated, idles low |
| sclk_n | output | 1 | Inverse of `sclk` |
| sdo | output | 1 | Serial data, MSB first |
| sdo_n | output | 1 | Inverse of `sdo` |
| frame_n | output | 1 | Active-low frame marker |

## Verification
All results follow from counting rising edges after reset release. A word accepted before boundary edge 64·m appears as frame cycle k in the cycle after edge 64·m+1+k. `in_ready` falls in the cycle after the accepting edge and rises again after the boundary edge. The bench model keeps its own edge count and holding-buffer state, and predicts every output for the cycle that follows each edge. It compares those predictions at the falling edge, when the outputs are stable. A separate receiver assembles bits on `sclk` rises and checks each finished word against the accepted words in order.

// File: rtl/swp_pkg.sv
package swp_pkg;
  typedef struct packed {
    logic frame_n;
    logic sclk;
    logic sdo;
  } line_t;
endpackage

// File: rtl/swp_slot_timer.sv
module swp_slot_timer #(
  parameter int SLOT_LEN  = 64,
  parameter int SCLK_DIV  = 3,
  parameter int FRAME_LEN = 48,
  localparam int PH_W = $clog2(SLOT_LEN),
  localparam int TR_W = $clog2(SCLK_DIV + 1)
) (
  input  logic clk,
  input  logic rst_n,
  output logic slot_end,
  output logic rise_pt,
  output logic in_window
);
  logic [PH_W-1:0] ph_q;
  logic [TR_W-1:0] tr_q;

  assign slot_end  = (ph_q == PH_W'(SLOT_LEN - 1));
  assign rise_pt   = (tr_q == TR_W'(SCLK_DIV - 1));
  assign in_window = (ph_q < PH_W'(FRAME_LEN));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= '0;
      tr_q <= '0;
    end else begin
      ph_q <= slot_end ? '0 : ph_q + 1'b1;
      tr_q <= (slot_end || rise_pt) ? '0 : tr_q + 1'b1;
    end
  end

  // R3: a slot end is always followed by a non-end cycle
  p_slot_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    slot_end |=> !slot_end);
endmodule

// File: rtl/swp_hold_buf.sv
module swp_hold_buf #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  input  logic         take,
  output logic         full,
  output logic [W-1:0] held
);
  logic         full_q;
  logic [W-1:0] data_q;
  logic         accept;

  assign accept   = in_valid && !full_q;
  assign in_ready = !full_q;
  assign full     = full_q;
  assign held     = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (accept) begin
      full_q <= 1'b1;
      data_q <= in_data;
    end else if (take) begin
      full_q <= 1'b0;
    end
  end

  p_accept_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  p_hold_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && !take) |=> (!in_ready && $stable(held)));
endmodule

// File: rtl/swp_shifter.sv
module swp_shifter
  import swp_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         slot_end,
  input  logic         rise_pt,
  input  logic         in_window,
  input  logic         word_ok,
  input  logic [W-1:0] word,
  output logic         take,
  output line_t        line_q
);
  logic         busy_q;
  logic [W-1:0] sh_q;
  logic         active;

  assign take   = slot_end && word_ok;
  assign active = busy_q && in_window;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sh_q   <= '0;
      line_q <= '{frame_n: 1'b1, sclk: 1'b0, sdo: 1'b0};
    end else begin
      if (slot_end) busy_q <= word_ok;
      if (take) sh_q <= word;
      else if (active && rise_pt) sh_q <= {sh_q[W-2:0], 1'b0};
      line_q.frame_n <= !active;
      line_q.sclk    <= active && rise_pt;
      line_q.sdo     <= active ? sh_q[W-1] : 1'b0;
    end
  end

  p_sclk_in_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
    line_q.sclk |-> !line_q.frame_n);

  p_idle_sdo_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    line_q.frame_n |-> !line_q.sdo);

  p_sclk_one_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    line_q.sclk |=> !line_q.sclk);

  p_sclk_two_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(line_q.sclk) |=> !line_q.sclk);

  p_lead_two_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(line_q.frame_n) |=> (!line_q.sclk ##1 line_q.sclk));

  p_tail_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_q.frame_n) |-> $past(line_q.sclk));

  p_sdo_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_q.sclk) |-> $stable(line_q.sdo));

  p_sdo_change_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(line_q.sdo) |-> ($fell(line_q.sclk) || $changed(line_q.frame_n)));
endmodule

// File: rtl/serial_word_port.sv
module serial_word_port
  import swp_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int SLOT_LEN = 64,
  parameter int SCLK_DIV = 3,
  localparam int FRAME_LEN = WORD_W * SCLK_DIV
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  output logic              sclk,
  output logic              sclk_n,
  output logic              sdo,
  output logic              sdo_n,
  output logic              frame_n
);
  logic              slot_end;
  logic              rise_pt;
  logic              in_window;
  logic              take;
  logic              full;
  logic [WORD_W-1:0] held;
  line_t             line_q;

  swp_slot_timer #(
    .SLOT_LEN (SLOT_LEN),
    .SCLK_DIV (SCLK_DIV),
    .FRAME_LEN(FRAME_LEN)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .slot_end (slot_end),
    .rise_pt  (rise_pt),
    .in_window(in_window)
  );

  swp_hold_buf #(.W(WORD_W)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_valid(in_valid),
    .in_ready(in_ready),
    .in_data (in_data),
    .take    (take),
    .full    (full),
    .held    (held)
  );

  swp_shifter #(.W(WORD_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .slot_end (slot_end),
    .rise_pt  (rise_pt),
    .in_window(in_window),
    .word_ok  (full),
    .word     (held),
    .take     (take),
    .line_q   (line_q)
  );

  assign sclk    = line_q.sclk;
  assign sdo     = line_q.sdo;
  assign frame_n = line_q.frame_n;
  assign sclk_n  = ~line_q.sclk;
  assign sdo_n   = ~line_q.sdo;
endmodule

// File: tb/tb_serial_word_port.sv
module tb_serial_word_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic        in_ready, sclk, sclk_n, sdo, sdo_n, frame_n;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  serial_word_port dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .sclk(sclk), .sclk_n(sclk_n), .sdo(sdo),
    .sdo_n(sdo_n), .frame_n(frame_n)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (time %0t)", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int          j = 0;
  bit          m_full = 0;
  logic [15:0] m_buf = '0;
  bit          f_on = 0;
  int          f_start = 0;
  logic [15:0] f_word = '0;
  logic [15:0] exp_q[$];

  always @(posedge clk) begin
    if (rst_n) begin
      bit acc, ld;
      j++;
      acc = in_valid && !m_full;
      ld  = (j % 64 == 0) && m_full;
      if (ld) begin
        f_on = 1; f_start = j + 1; f_word = m_buf;
      end
      if (acc) begin
        m_buf = in_data;
        exp_q.push_back(in_data);
      end
      m_full = acc ? 1'b1 : (ld ? 1'b0 : m_full);
    end
  end

  // per-cycle comparison and receiver
  logic        p_sclk = 0, p_frame = 1;
  logic [15:0] rx = '0;
  int          nbits = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      chk(sclk == 1'b0, "R1 sclk in reset", sclk, 0);
      chk(sdo == 1'b0, "R1 sdo in reset", sdo, 0);
      chk(frame_n == 1'b1, "R1 frame_n in reset", frame_n, 1);
      chk(in_ready == 1'b1, "R1 in_ready in reset", in_ready, 1);
    end else if (!done) begin
      int k; bit act; bit e_sclk, e_sdo;
      k = j - f_start;
      act = f_on && (k >= 0) && (k < 48);
      e_sclk = act && (k % 3 == 2);
      e_sdo  = act ? f_word[15 - k/3] : 1'b0;
      chk(frame_n == !act, "R5 frame_n", frame_n, !act);
      chk(sclk == e_sclk, act ? "R4 sclk" : "R7 sclk idle", sclk, e_sclk);
      chk(sdo == e_sdo, act ? "R6 sdo bit" : "R7 sdo idle", sdo, e_sdo);
      chk(sclk_n == ~sclk, "R8 sclk_n", sclk_n, !sclk);
      chk(sdo_n == ~sdo, "R8 sdo_n", sdo_n, !sdo);
      chk(in_ready == !m_full, "R2 in_ready", in_ready, !m_full);
      if (p_frame && !frame_n) begin
        chk((j - 1) % 64 == 0, "R3 frame start on slot grid", (j - 1) % 64, 0);
        nbits = 0;
      end
      if (sclk && !p_sclk) begin
        rx = {rx[14:0], sdo};
        nbits++;
      end
      if (!p_frame && frame_n) begin
        logic [15:0] w;
        w = (exp_q.size() > 0) ? exp_q.pop_front() : 16'hxxxx;
        chk(nbits == 16, "R4 pulses per frame", nbits, 16);
        chk(rx === w, "R9 received word", rx, w);
      end
      p_sclk = sclk;
      p_frame = frame_n;
    end
  end

  task automatic send(input logic [15:0] w);
    bit r;
    in_valid = 1'b1;
    in_data  = w;
    while (1) begin
      r = in_ready;
      @(negedge clk);
      if (r) break;
    end
    in_valid = 1'b0;
  endtask

  task automatic junk(input logic [15:0] w, input int n);
    in_valid = 1'b1;
    in_data  = w;
    repeat (n) @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (70) @(negedge clk);           // idle slot: R7
    send(16'hA5C3);                       // R6 mixed bits
    junk(16'hDEAD, 3);                    // R2 ignored while full
    repeat (130) @(negedge clk);
    send(16'h8000);                       // R9 back-to-back run
    send(16'h7FFF);
    send(16'h0000);
    send(16'hFFFF);
    send(16'h0001);
    repeat (200) @(negedge clk);          // idle slots between words
    send(16'h1234);
    repeat (150) @(negedge clk);
    chk(exp_q.size() == 0, "R9 all words delivered", exp_q.size(), 0);
    finish_run();
  end
endmodule